// File: doc/BRIEF.md
# Three-Voice Square-Wave Sound Generator

This block makes square-wave sound for three channels from a single system clock. Each channel has its own programmable tone divider. A shared pseudo-random noise source and a shared envelope generator serve all three channels. A fixed divide-by-16 prescaler turns the system clock into a work tick, and every programmable divider advances only on that tick.

Software sets the block up through sixteen byte-wide configuration slots. Each write takes two strobes. A select strobe latches the slot index from the low nibble of the data bus. A later write strobe stores the whole data byte into the slot that was selected. Both strobes are single-cycle pulses and are always accepted, so the block never pushes back on the writer.

For each channel the output is a 4-bit drive word. Each bit of the word is meant to switch one tap of an external weighted resistor ladder. When the channel gate is open, the word carries the channel level. When the gate is closed, the word is zero.

Top module: `psg3_core`

## Requirements
- R1: A cycle with `sel_stb` high latches `bus_data[3:0]` as the slot index. A cycle with `wr_stb` high stores `bus_data` into the slot latched before that cycle. Writes to slots 14 and 15 have no effect on any output.
- R2: A work tick occurs once every 16 clock cycles, in the 16th cycle after reset. Every divider advances only on a work tick.
- R3: Channel k (k = 0, 1, 2 for A, B, C) takes its tone period P from bits 3:0 of slot 2k+1 (high part) and from slot 2k (low byte). A period of 0 acts as 1. The tone bit starts at 0 after reset and inverts once every P work ticks.
- R4: Slot 6 bits 4:0 give the noise period N, where 0 acts as 1. The noise phase inverts every N work ticks. Each time the phase goes from 0 to 1, a 20-stage shift chain moves by one stage. The new first stage is the XOR of stage 20 and stage 3. The noise bit is stage 20, and reset loads all stages with ones.
- R5: Slot 7 is the mixer. Bit k set to 1 disables the tone of channel k, and bit k+3 set to 1 disables noise for channel k. A disabled source counts as 1, and the channel gate is the AND of the two sources.
- R6: Slots 8, 9 and 10 set the levels of channels A, B and C. When bit 4 is 1 the level is the envelope value; otherwise the level is bits 3:0. The drive output equals the level while the gate is 1 and is 0 otherwise.
- R7: Slot 11 (low byte) and slot 12 (high byte) form the envelope period E, where 0 acts as 1. The envelope takes one step every E work ticks, and the step counter restarts when the shape slot is written.
- R8: Slot 13 is the envelope shape: bit 3 continue, bit 2 attack, bit 1 alternate, bit 0 hold. A write to it restarts a 16-step ramp at 0 when attack is 1 or at 15 when attack is 0. Each step moves the ramp by one.
- R9: At the end of a ramp the envelope acts as follows. With continue at 0 it holds 0. With continue and hold both 1 it holds the final value, or the opposite end if alternate is 1. With continue at 1 and hold at 0 it starts a new ramp, and the direction flips if alternate is 1.
- R10: After reset all drive outputs are 0, and the envelope holds 0 until the shape slot is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_stb | input | 1 | Slot-select strobe; latches index from bus_data[3:0] |
| wr_stb | input | 1 | Slot-write strobe; stores bus_data into selected slot |
| bus_data | input | 8 | Data bus |
| drv_a | output | 4 | Weighted-tap drive for channel A |
| drv_b | output | 4 | Weighted-tap drive for channel B |
| drv_c | output | 4 | Weighted-tap drive for channel C |

## Verification
Some properties are checked on every cycle:
- the tick spacing, using a counter that is independent of the design;
- that the tone and noise bits stay still between their divider events;
- that the slot index changes only on a select strobe;
- that the envelope level changes only on a step or a restart, and stays frozen once held;
- that a restart lands on one end of the range.

The bench's scenarios show the exact values:
- the periods, including the zero-as-one rule;
- the order of the shift chain;
- how the mixer combines sources;
- the final held level for each shape;
- that writes to the unused slots are ignored.

A behavioural model in the bench predicts each drive output on every clock.

// File: rtl/psg3_pkg.sv
package psg3_pkg;
  localparam int DATA_W   = 8;
  localparam int NSLOT    = 16;
  localparam int IDX_W    = $clog2(NSLOT);
  localparam int NCH      = 3;
  localparam int LVL_W    = 4;
  localparam int PRE_DIV  = 16;
  localparam int PRE_W    = $clog2(PRE_DIV);
  localparam int TONE_HI  = 4;
  localparam int TONE_W   = DATA_W + TONE_HI;
  localparam int NOISE_W  = 5;
  localparam int ENV_W    = 2 * DATA_W;
  localparam int CHAIN_N  = 20;
  localparam int CHAIN_TAP = 2;

  localparam logic [IDX_W-1:0] SLOT_NOISE = 4'd6;
  localparam logic [IDX_W-1:0] SLOT_MIX   = 4'd7;
  localparam logic [IDX_W-1:0] SLOT_LVL0  = 4'd8;
  localparam logic [IDX_W-1:0] SLOT_ELO   = 4'd11;
  localparam logic [IDX_W-1:0] SLOT_EHI   = 4'd12;
  localparam logic [IDX_W-1:0] SLOT_SHAPE = 4'd13;
  localparam logic [IDX_W-1:0] SLOT_LAST  = 4'd13;

  typedef struct packed {
    logic cont;
    logic att;
    logic alt;
    logic hold;
  } shape_t;
endpackage

// File: rtl/psg3_slots.sv
module psg3_slots
  import psg3_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel_stb,
  input  logic                         wr_stb,
  input  logic [DATA_W-1:0]            bus_data,
  output logic [IDX_W-1:0]             idx,
  output logic [NSLOT-1:0][DATA_W-1:0] slots,
  output logic                         shape_wr
);
  assign shape_wr = wr_stb && (idx == SLOT_SHAPE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (sel_stb) begin
      idx <= bus_data[IDX_W-1:0];
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s <= int'(SLOT_LAST)) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          slots[s] <= '0;
        end else if (wr_stb && idx == IDX_W'(s)) begin
          slots[s] <= bus_data;
        end
      end
    end else begin : g_dead
      assign slots[s] = '0;
    end
  end
endmodule

// File: rtl/psg3_divider.sv
module psg3_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] period,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic [W:0]   nxt;
  logic [W:0]   eff;
  logic         hit;

  assign nxt   = {1'b0, cnt} + (W+1)'(1);
  assign eff   = (period == '0) ? (W+1)'(1) : {1'b0, period};
  assign hit   = (nxt >= eff);
  assign pulse = tick && hit && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= hit ? '0 : nxt[W-1:0];
    end
  end
endmodule

// File: rtl/psg3_noise.sv
module psg3_noise
  import psg3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic noise_bit
);
  logic [CHAIN_N-1:0] chain;
  logic               phase;
  logic               fb;

  assign fb        = chain[CHAIN_N-1] ^ chain[CHAIN_TAP];
  assign noise_bit = chain[CHAIN_N-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      phase <= 1'b0;
    end else if (pulse) begin
      phase <= ~phase;
      if (!phase) begin
        chain <= {chain[CHAIN_N-2:0], fb};
      end
    end
  end
endmodule

// File: rtl/psg3_envelope.sv
module psg3_envelope
  import psg3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic             restart_att,
  input  shape_t           shape,
  output logic [LVL_W-1:0] level,
  output logic             held
);
  localparam logic [LVL_W-1:0] TOP = '1;

  logic [LVL_W-1:0] pos;
  logic             rising;
  logic             zero;

  assign level = zero ? '0 : (rising ? pos : ~pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      rising <= 1'b0;
      held   <= 1'b1;
      zero   <= 1'b1;
    end else if (restart) begin
      pos    <= '0;
      rising <= restart_att;
      held   <= 1'b0;
      zero   <= 1'b0;
    end else if (step && !held) begin
      if (pos != TOP) begin
        pos <= pos + LVL_W'(1);
      end else if (!shape.cont) begin
        held <= 1'b1;
        zero <= 1'b1;
      end else if (shape.hold) begin
        held <= 1'b1;
        if (shape.alt) rising <= ~rising;
      end else begin
        pos <= '0;
        if (shape.alt) rising <= ~rising;
      end
    end
  end
endmodule

// File: rtl/psg3_core.sv
module psg3_core
  import psg3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] bus_data,
  output logic [LVL_W-1:0]  drv_a,
  output logic [LVL_W-1:0]  drv_b,
  output logic [LVL_W-1:0]  drv_c
);
  logic [PRE_W-1:0]             pre_cnt;
  logic                         tick;
  logic [IDX_W-1:0]             idx;
  logic [NSLOT-1:0][DATA_W-1:0] slots;
  logic                         shape_wr;
  logic [NCH-1:0]               tone_pulse;
  logic [NCH-1:0]               tone_q;
  logic                         noise_pulse;
  logic                         noise_bit;
  logic                         env_step;
  logic [LVL_W-1:0]             env_lvl;
  logic                         env_held;
  logic [NCH-1:0][LVL_W-1:0]    drv;

  assign tick = (pre_cnt == PRE_W'(PRE_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + PRE_W'(1);
  end

  psg3_slots u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_stb  (sel_stb),
    .wr_stb   (wr_stb),
    .bus_data (bus_data),
    .idx      (idx),
    .slots    (slots),
    .shape_wr (shape_wr)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_tone
    psg3_divider #(.W(TONE_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .clr    (1'b0),
      .period ({slots[2*k+1][TONE_HI-1:0], slots[2*k]}),
      .pulse  (tone_pulse[k])
    );
    always_ff @(posedge clk) begin
      if (!rst_n)             tone_q[k] <= 1'b0;
      else if (tone_pulse[k]) tone_q[k] <= ~tone_q[k];
    end
  end

  psg3_divider #(.W(NOISE_W)) u_noise_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (1'b0),
    .period (slots[SLOT_NOISE][NOISE_W-1:0]),
    .pulse  (noise_pulse)
  );

  psg3_noise u_noise (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse     (noise_pulse),
    .noise_bit (noise_bit)
  );

  psg3_divider #(.W(ENV_W)) u_env_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (shape_wr),
    .period ({slots[SLOT_EHI], slots[SLOT_ELO]}),
    .pulse  (env_step)
  );

  psg3_envelope u_env (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (env_step),
    .restart     (shape_wr),
    .restart_att (bus_data[2]),
    .shape       (shape_t'(slots[SLOT_SHAPE][3:0])),
    .level       (env_lvl),
    .held        (env_held)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    logic             tone_ok;
    logic             noise_ok;
    logic [DATA_W-1:0] lvl_slot;
    logic [LVL_W-1:0] lvl;
    assign lvl_slot = slots[int'(SLOT_LVL0) + k];
    assign tone_ok  = tone_q[k] | slots[SLOT_MIX][k];
    assign noise_ok = noise_bit | slots[SLOT_MIX][k + NCH];
    assign lvl      = lvl_slot[LVL_W] ? env_lvl : lvl_slot[LVL_W-1:0];
    assign drv[k]   = (tone_ok && noise_ok) ? lvl : '0;
  end

  assign drv_a = drv[0];
  assign drv_b = drv[1];
  assign drv_c = drv[2];
endmodule

// File: rtl/psg3_checker.sv
module psg3_checker
  import psg3_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sel_stb,
  input logic             tick,
  input logic [IDX_W-1:0] idx,
  input logic [NCH-1:0]   tone_q,
  input logic             noise_pulse,
  input logic             noise_bit,
  input logic             env_step,
  input logic             shape_wr,
  input logic             env_held,
  input logic [LVL_W-1:0] env_lvl
);
  logic [PRE_W-1:0] ref_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_cnt <= '0;
    else        ref_cnt <= ref_cnt + PRE_W'(1);
  end

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (ref_cnt == PRE_W'(PRE_DIV - 1)));

  p_index_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_stb |=> $stable(idx));

  p_tone_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tone_q));

  p_noise_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !noise_pulse |=> $stable(noise_bit));

  p_env_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(env_step || shape_wr) |=> $stable(env_lvl));

  p_env_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shape_wr |=> (env_lvl == '0 || env_lvl == '1));

  p_env_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (env_held && !shape_wr) |=> $stable(env_lvl));
endmodule

bind psg3_core psg3_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_stb     (sel_stb),
  .tick        (tick),
  .idx         (idx),
  .tone_q      (tone_q),
  .noise_pulse (noise_pulse),
  .noise_bit   (noise_bit),
  .env_step    (env_step),
  .shape_wr    (shape_wr),
  .env_held    (env_held),
  .env_lvl     (env_lvl)
);

// File: tb/psg3_core_tb.sv
module psg3_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic [3:0] drv_a, drv_b, drv_c;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    cmp_en = 1'b0;
  string tag = "R10";

  always #4 clk = ~clk;

  psg3_core u_dut (
    .clk(clk), .rst_n(rst_n), .sel_stb(sel_stb), .wr_stb(wr_stb),
    .bus_data(bus_data), .drv_a(drv_a), .drv_b(drv_b), .drv_c(drv_c)
  );

  // behavioural reference model
  int        m_pc, m_idx, m_ncnt, m_ecnt, m_step;
  int        m_reg [16];
  int        m_tcnt [3];
  bit        m_tone [3];
  bit        m_nph, m_dir, m_held, m_zero;
  logic [19:0] m_chain;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_idx = 0; m_ncnt = 0; m_ecnt = 0; m_step = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
      for (int k = 0; k < 3; k++) begin m_tcnt[k] = 0; m_tone[k] = 0; end
      m_nph = 0; m_chain = '1; m_dir = 0; m_held = 1; m_zero = 1;
    end else begin
      bit tk;
      int per;
      tk = (m_pc == 15);
      m_pc = (m_pc + 1) % 16;
      if (tk) begin
        for (int k = 0; k < 3; k++) begin
          per = (m_reg[2*k+1] % 16) * 256 + m_reg[2*k];
          if (per == 0) per = 1;
          if (m_tcnt[k] + 1 >= per) begin m_tcnt[k] = 0; m_tone[k] = !m_tone[k]; end
          else m_tcnt[k]++;
        end
        per = m_reg[6] % 32;
        if (per == 0) per = 1;
        if (m_ncnt + 1 >= per) begin
          m_ncnt = 0;
          if (!m_nph) m_chain = {m_chain[18:0], m_chain[19] ^ m_chain[2]};
          m_nph = !m_nph;
        end else m_ncnt++;
      end
      if (wr_stb && m_idx == 13) begin
        m_ecnt = 0; m_step = 0; m_dir = bus_data[2]; m_held = 0; m_zero = 0;
      end else if (tk) begin
        per = m_reg[12] * 256 + m_reg[11];
        if (per == 0) per = 1;
        if (m_ecnt + 1 >= per) begin
          m_ecnt = 0;
          if (!m_held) begin
            if (m_step < 15) m_step++;
            else if (!m_reg[13][3]) begin m_held = 1; m_zero = 1; end
            else if (m_reg[13][0]) begin m_held = 1; if (m_reg[13][1]) m_dir = !m_dir; end
            else begin m_step = 0; if (m_reg[13][1]) m_dir = !m_dir; end
          end
        end else m_ecnt++;
      end
      if (wr_stb && m_idx < 14) m_reg[m_idx] = bus_data;
      if (sel_stb) m_idx = bus_data % 16;
    end
  end

  function automatic int exp_drv(int k);
    int env, lvl;
    bit g;
    env = m_zero ? 0 : (m_dir ? m_step : 15 - m_step);
    g = (m_tone[k] | m_reg[7][k]) & (m_chain[19] | m_reg[7][k+3]);
    lvl = m_reg[8+k][4] ? env : m_reg[8+k] % 16;
    return g ? lvl : 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check(tag, "drv_a vs model", drv_a, exp_drv(0));
      check(tag, "drv_b vs model", drv_b, exp_drv(1));
      check(tag, "drv_c vs model", drv_c, exp_drv(2));
    end
  end

  task automatic wr_slot(int s, int v);
    @(negedge clk); sel_stb = 1; bus_data = 8'(s);
    @(negedge clk); sel_stb = 0; wr_stb = 1; bus_data = 8'(v);
    @(negedge clk); wr_stb = 0; bus_data = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    check("R10", "drv_a in reset", drv_a, 0);
    check("R10", "drv_b in reset", drv_b, 0);
    rst_n = 1;
    cmp_en = 1;
    idle(40);
    check("R10", "drv_c after reset", drv_c, 0);

    // R5 / R6: mixer fully disabled, fixed levels
    tag = "R6";
    wr_slot(7, 8'h3F);
    wr_slot(8, 9); wr_slot(9, 5); wr_slot(10, 8'hEF);
    idle(2);
    check("R6", "fixed level A", drv_a, 9);
    check("R6", "fixed level B", drv_b, 5);
    check("R6", "fixed level C masked", drv_c, 15);

    // R1: unused slots ignored, index retained
    tag = "R1";
    wr_slot(14, 8'h00); wr_slot(15, 8'h00);
    idle(20);
    check("R1", "slot14/15 write A", drv_a, 9);
    check("R1", "slot14/15 write C", drv_c, 15);
    @(negedge clk); sel_stb = 1; bus_data = 8'h39;
    @(negedge clk); sel_stb = 0; wr_stb = 1; bus_data = 8'h02;
    @(negedge clk); wr_stb = 0; bus_data = 8'h00;
    @(negedge clk); wr_stb = 1; bus_data = 8'h07;
    @(negedge clk); wr_stb = 0;
    idle(2);
    check("R1", "index kept for second write", drv_b, 7);

    // R2 / R3: tones only
    tag = "R3";
    wr_slot(0, 1); wr_slot(1, 0);
    wr_slot(2, 3); wr_slot(3, 8'hF0);
    wr_slot(4, 0); wr_slot(5, 0);
    wr_slot(7, 8'h38);
    idle(800);
    tag = "R2";
    wr_slot(2, 8'h00); wr_slot(3, 1);
    idle(600);

    // R4: noise only
    tag = "R4";
    wr_slot(7, 8'h07);
    wr_slot(6, 8'hE1);
    begin
      int hi = 0, lo = 0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (drv_a != 0) hi++; else lo++;
      end
      check("R4", "noise produced ones", int'(hi > 0), 1);
      check("R4", "noise produced zeros", int'(lo > 0), 1);
    end
    wr_slot(6, 3);
    idle(1500);

    // R5: tone and noise combined, mixed per channel
    tag = "R5";
    wr_slot(7, 8'h00); idle(1200);
    wr_slot(7, 8'h11); idle(1200);

    // R7 / R8 / R9: envelope
    tag = "R8";
    wr_slot(7, 8'h3F);
    wr_slot(8, 8'h10); wr_slot(9, 8'h10); wr_slot(10, 4);
    check("R10", "envelope idle at zero", drv_a, 0);
    wr_slot(11, 1); wr_slot(12, 0);
    wr_slot(13, 8'h0C);
    check("R8", "attack starts at 0", drv_a, 0);
    idle(16);
    check("R8", "attack first step", drv_a, 1);
    wr_slot(13, 8'h08);
    check("R8", "decay starts at 15", drv_a, 15);
    idle(33);
    check("R8", "decay two steps", drv_a, 13);

    tag = "R9";
    wr_slot(13, 8'h0D); idle(400);
    check("R9", "attack-hold final", drv_a, 15);
    wr_slot(13, 8'h0F); idle(400);
    check("R9", "attack-alt-hold final", drv_a, 0);
    wr_slot(13, 8'h0B); idle(400);
    check("R9", "decay-alt-hold final", drv_b, 15);
    wr_slot(13, 8'h04); idle(400);
    check("R9", "attack one-shot final", drv_a, 0);
    check("R9", "fixed channel untouched", drv_c, 4);
    wr_slot(13, 8'h0E); idle(1100);
    wr_slot(13, 8'h08); idle(700);

    tag = "R7";
    wr_slot(12, 1); wr_slot(11, 0);
    wr_slot(13, 8'h08);
    idle(2000);
    check("R7", "slow envelope still at 15", drv_a, 15);
    wr_slot(12, 0); wr_slot(11, 3);
    wr_slot(13, 8'h0C);
    idle(49);
    check("R7", "period 3 first step", drv_a, 1);
    idle(300);

    cmp_en = 0;
    summary();
  end
endmodule